// File: doc/BRIEF.md
# Transmit Descriptor Chain Reader

This block walks a chain of transmit descriptors held in memory and turns the buffers they point to into frames on a byte-stream output. Software fills the descriptors, sets the queue base while the engine is idle, and pulses a start input. The engine then reads each descriptor, streams the referenced buffer bytes one per cycle, and closes a frame at the descriptor flagged as last. It marks the frame handed back by setting the used flag in the first descriptor of that frame, then moves on to the next descriptor. Fetching halts at a descriptor that is already used.

Two faults abort a frame. The first is meeting a used descriptor before the last-buffer flag. The second is a buffer read that memory does not answer within a set number of cycles. In either case the engine pulses an abort marker on the stream, records the fault in the first descriptor and in a sticky status register, and returns its pointer to the queue base. Status bits are cleared by writing ones to them.

The memory port is a single request/acknowledge port for 32-bit words. A request is held until it is acknowledged, with one exception: the engine may withdraw a buffer read it has given up on.

Top module: `txd_chain_reader`

## Requirements
- R1: A descriptor is 8 bytes at a word-aligned address. Its address word, at offset 0, gives the buffer start; the low two bits of that word are ignored. Its control word, at offset 4, holds the byte count in bits 10:0, the last-buffer flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31. The engine reads the address word first and the control word second, and it places consecutive descriptors 8 bytes apart.
- R2: Each buffer produces exactly its byte count on `out_data`, in increasing address order, with the low byte of each 32-bit word first. A buffer with a count of zero produces no bytes. No memory request is made while a fetched word still has bytes to send.
- R3: A frame covers consecutive descriptors up to and including the one with the last-buffer flag. `out_last` is high only together with the final byte of that descriptor's buffer.
- R4: After a descriptor whose wrap flag is set, the next descriptor is fetched from the queue base and not from the following 8 bytes.
- R5: When a frame ends normally, the engine writes the control word of the frame's first descriptor back to its offset-4 address. The written word has bit 31 set and every other bit as fetched. Descriptors after the first are not written. Fetching then continues with the next descriptor.
- R6: A descriptor whose used flag is set, met at the start of a frame, ends the walk. The engine goes idle with no stream output, no memory write and no status change.
- R7: A used descriptor met after a frame has started but before its last buffer aborts the frame. The first descriptor's control word is written back with bits 31 and 27 set. Status bit 3 is set, `out_abort` pulses for one cycle, and the pointer returns to the queue base, so the next start fetches from the base.
- R8: If a buffer read is not acknowledged within STALL_LIMIT cycles, the engine withdraws the request and aborts the frame. The first descriptor's control word is written back with bits 31 and 28 set. Status bit 4 is set, `out_abort` pulses, and the pointer returns to the queue base.
- R9: Status bit 5 (frame sent) becomes set in the cycle after the acknowledge of a normal write-back. No fault write-back sets it.
- R10: Status bits 5, 4 and 3 are sticky. Writing a 1 to a bit position through the clear port clears that bit and no other.
- R11: While the engine is busy, a start pulse or a queue-base write has no effect.
- R12: After reset the engine is idle, `tx_status` is zero and no memory request is made. Status bit 0 shows busy. The first memory request, a read of the queue base address, is presented in the cycle after the start pulse is sampled. While idle, the engine makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin walking the chain |
| qbase_we | input | 1 | Queue base write strobe (honoured only while idle) |
| qbase_wdata | input | AW | New queue base, also loaded into the fetch pointer |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 8 | Ones mark the status bits to clear |
| tx_status | output | 8 | Bit 0 busy, bit 3 exhausted, bit 4 underrun, bit 5 frame sent |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | A frame byte is present |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_abort | output | 1 | One-cycle pulse: the frame in progress is dropped |

## Verification
The first memory request comes one cycle after start is sampled, so the bench samples at the falling edge right after it drives start. The frame-sent bit follows the write-back acknowledge by one cycle. The bench therefore finds the falling edge where the write-back and its acknowledge are both visible, checks that the bit is still clear there, and checks that it is set one falling edge later. Stream bytes, end markers, abort pulses and memory writes are gathered by a monitor on every falling edge. Content, position and count checks run only after busy has dropped, so the exact cycle of any single byte never matters. The stalled-read abort is due STALL_LIMIT cycles after the stalled request, and the bench allows for it by waiting for idle under a bounded loop.

// File: rtl/txd_pkg.sv
// Shared constants and types for the transmit descriptor chain reader.
// Assumes 32-bit memory words and byte addresses.
package txd_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LEN_W    = 11;
    localparam int unsigned ST_W     = 8;

    // Control word fields that the engine decodes or writes back.
    localparam int unsigned CW_LAST  = 15;
    localparam int unsigned CW_EXH   = 27;
    localparam int unsigned CW_UND   = 28;
    localparam int unsigned CW_WRAP  = 30;
    localparam int unsigned CW_USED  = 31;

    // Status register bit positions.
    localparam int unsigned SB_BUSY  = 0;
    localparam int unsigned SB_EXH   = 3;
    localparam int unsigned SB_UND   = 4;
    localparam int unsigned SB_SENT  = 5;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GET_ADDR,
        SQ_GET_CTRL,
        SQ_MOVE,
        SQ_STEP,
        SQ_CLOSE
    } seq_state_e;
endpackage

// File: rtl/txd_unpacker.sv
// Holds one fetched buffer word and hands its bytes out one per cycle,
// low byte first, until the buffer's byte count is used up.
// Assumes buffers start on a word boundary and that a word is loaded
// only while need_word is high.
module txd_unpacker import txd_pkg::*; #(
    parameter int unsigned CNT_W  = LEN_W,
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_load,
    input  logic [CNT_W-1:0]  len_in,
    input  logic              last_in,
    input  logic              word_load,
    input  logic [DATA_W-1:0] word_in,
    input  logic              flush,
    output logic              need_word,
    output logic              buf_empty,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last
);
    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned IDX_W = $clog2(BYTES);

    logic [CNT_W-1:0]  remain_q;
    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              hold_q;
    logic              last_q;
    logic              word_spent;

    // The held word is finished after its top byte or the buffer's final byte.
    assign word_spent = (idx_q == IDX_W'(BYTES - 1)) || (remain_q == CNT_W'(1));

    // Track the remaining count, the held word and the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            word_q   <= '0;
            idx_q    <= '0;
            hold_q   <= 1'b0;
            last_q   <= 1'b0;
        end else if (flush) begin
            remain_q <= '0;
            hold_q   <= 1'b0;
        end else if (len_load) begin
            remain_q <= len_in;
            last_q   <= last_in;
            idx_q    <= '0;
            hold_q   <= 1'b0;
        end else if (word_load) begin
            word_q   <= word_in;
            idx_q    <= '0;
            hold_q   <= 1'b1;
        end else if (hold_q) begin
            remain_q <= remain_q - CNT_W'(1);
            idx_q    <= idx_q + IDX_W'(1);
            if (word_spent) hold_q <= 1'b0;
        end
    end

    // Present the current byte and the handshake flags to the sequencer.
    assign need_word  = !hold_q && (remain_q != '0);
    assign buf_empty  = !hold_q && (remain_q == '0);
    assign byte_valid = hold_q;
    assign byte_data  = 8'(word_q >> {idx_q, 3'b000});
    assign byte_last  = hold_q && last_q && (remain_q == CNT_W'(1));
endmodule

// File: rtl/txd_status_reg.sv
// Sticky status bits with write-one-to-clear, plus a live busy bit.
// A set and a clear of the same bit in one cycle leaves the bit set.
module txd_status_reg import txd_pkg::*; #(
    parameter int unsigned W = ST_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         set_sent,
    input  logic         set_exh,
    input  logic         set_und,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] status
);
    logic [W-1:0] set_vec;
    logic [W-1:0] sticky_q;

    // Gather the event pulses into their bit positions.
    always_comb begin
        set_vec          = '0;
        set_vec[SB_SENT] = set_sent;
        set_vec[SB_EXH]  = set_exh;
        set_vec[SB_UND]  = set_und;
    end

    // Hold the sticky bits until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~(clr_we ? clr_data : '0)) | set_vec;
    end

    // Merge the live busy indication into the visible word.
    assign status = sticky_q | W'(busy);
endmodule

// File: rtl/txd_sequencer.sv
// Walks the descriptor chain: it fetches the address and control words,
// drives buffer word reads for the unpacker, steps or wraps the pointer,
// and writes the first descriptor's control word back at the frame's end.
// Assumes memory holds a request until acknowledge, and that read data is
// valid in the acknowledge cycle.
module txd_sequencer import txd_pkg::*; #(
    parameter int unsigned AW          = 16,
    parameter int unsigned STALL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              base_we,
    input  logic [AW-1:0]     base_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              len_load,
    output logic [LEN_W-1:0]  len_val,
    output logic              last_val,
    output logic              word_load,
    output logic              flush,
    input  logic              need_word,
    input  logic              buf_empty,
    output logic              set_sent,
    output logic              set_exh,
    output logic              set_und,
    output logic              abort,
    output logic              busy
);
    localparam int unsigned CNT_W = $clog2(STALL_LIMIT + 1);

    seq_state_e        state_q;
    logic [AW-1:0]     base_q, ptr_q, first_q, data_addr_q;
    logic [WORD_W-1:0] first_ctrl_q;
    logic              in_frame_q, last_q, wrap_q, exh_q, und_q, abort_q;
    logic [CNT_W-1:0]  wait_q;
    logic              timeout, closing;

    // A buffer read has waited its full allowance without an acknowledge.
    assign timeout = (state_q == SQ_MOVE) && need_word && !mem_ack &&
                     (wait_q == CNT_W'(STALL_LIMIT - 1));
    assign closing = (state_q == SQ_CLOSE) && mem_ack;

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        unique case (state_q)
            SQ_GET_ADDR: mem_req = 1'b1;
            SQ_GET_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'(4);
            end
            SQ_MOVE: begin
                mem_req  = need_word;
                mem_addr = data_addr_q;
            end
            SQ_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_q + AW'(4);
                mem_wdata = first_ctrl_q;
                mem_wdata[CW_USED] = 1'b1;
                mem_wdata[CW_EXH]  = first_ctrl_q[CW_EXH] | exh_q;
                mem_wdata[CW_UND]  = first_ctrl_q[CW_UND] | und_q;
            end
            default: ;
        endcase
    end

    // Strobes to the unpacker and to the status register.
    assign len_load  = (state_q == SQ_GET_CTRL) && mem_ack && !mem_rdata[CW_USED];
    assign len_val   = mem_rdata[LEN_W-1:0];
    assign last_val  = mem_rdata[CW_LAST];
    assign word_load = (state_q == SQ_MOVE) && need_word && mem_ack;
    assign flush     = timeout;
    assign set_sent  = closing && !exh_q && !und_q;
    assign set_exh   = closing && exh_q;
    assign set_und   = closing && und_q;
    assign abort     = abort_q;
    assign busy      = (state_q != SQ_IDLE);

    // Advance the chain walk one step per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SQ_IDLE;
            base_q       <= '0;
            ptr_q        <= '0;
            first_q      <= '0;
            data_addr_q  <= '0;
            first_ctrl_q <= '0;
            in_frame_q   <= 1'b0;
            last_q       <= 1'b0;
            wrap_q       <= 1'b0;
            exh_q        <= 1'b0;
            und_q        <= 1'b0;
            abort_q      <= 1'b0;
            wait_q       <= '0;
        end else begin
            abort_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (base_we) begin
                        base_q <= base_wdata;
                        ptr_q  <= base_wdata;
                    end
                    if (start) state_q <= SQ_GET_ADDR;
                end
                SQ_GET_ADDR: begin
                    if (mem_ack) begin
                        data_addr_q <= mem_rdata[AW-1:0] & ~AW'(3);
                        state_q     <= SQ_GET_CTRL;
                    end
                end
                SQ_GET_CTRL: begin
                    if (mem_ack) begin
                        if (mem_rdata[CW_USED]) begin
                            if (in_frame_q) begin
                                exh_q   <= 1'b1;
                                abort_q <= 1'b1;
                                state_q <= SQ_CLOSE;
                            end else begin
                                state_q <= SQ_IDLE;
                            end
                        end else begin
                            if (!in_frame_q) begin
                                first_q      <= ptr_q;
                                first_ctrl_q <= mem_rdata;
                                in_frame_q   <= 1'b1;
                            end
                            last_q  <= mem_rdata[CW_LAST];
                            wrap_q  <= mem_rdata[CW_WRAP];
                            wait_q  <= '0;
                            state_q <= SQ_MOVE;
                        end
                    end
                end
                SQ_MOVE: begin
                    if (buf_empty) begin
                        state_q <= SQ_STEP;
                    end else if (need_word) begin
                        if (mem_ack) begin
                            data_addr_q <= data_addr_q + AW'(4);
                            wait_q      <= '0;
                        end else if (timeout) begin
                            und_q   <= 1'b1;
                            abort_q <= 1'b1;
                            state_q <= SQ_CLOSE;
                        end else begin
                            wait_q <= wait_q + CNT_W'(1);
                        end
                    end
                end
                SQ_STEP: begin
                    ptr_q   <= wrap_q ? base_q : ptr_q + AW'(8);
                    state_q <= last_q ? SQ_CLOSE : SQ_GET_ADDR;
                end
                SQ_CLOSE: begin
                    if (mem_ack) begin
                        in_frame_q <= 1'b0;
                        if (exh_q || und_q) begin
                            ptr_q   <= base_q;
                            exh_q   <= 1'b0;
                            und_q   <= 1'b0;
                            state_q <= SQ_IDLE;
                        end else begin
                            state_q <= SQ_GET_ADDR;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txd_chain_reader.sv
// Top level: sequencer, byte unpacker and status register wired together.
// Assumes the memory behind the port answers descriptor and write-back
// requests eventually; only buffer reads are timed out.
module txd_chain_reader import txd_pkg::*; #(
    parameter int unsigned AW          = 16,
    parameter int unsigned STALL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              qbase_we,
    input  logic [AW-1:0]     qbase_wdata,
    input  logic              stat_clr_we,
    input  logic [ST_W-1:0]   stat_clr_data,
    output logic [ST_W-1:0]   tx_status,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              out_abort
);
    logic             len_load, last_val, word_load, flush;
    logic [LEN_W-1:0] len_val;
    logic             need_word, buf_empty;
    logic             set_sent, set_exh, set_und, busy;

    txd_sequencer #(.AW(AW), .STALL_LIMIT(STALL_LIMIT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_we    (qbase_we),
        .base_wdata (qbase_wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .len_load   (len_load),
        .len_val    (len_val),
        .last_val   (last_val),
        .word_load  (word_load),
        .flush      (flush),
        .need_word  (need_word),
        .buf_empty  (buf_empty),
        .set_sent   (set_sent),
        .set_exh    (set_exh),
        .set_und    (set_und),
        .abort      (out_abort),
        .busy       (busy)
    );

    txd_unpacker #(.CNT_W(LEN_W), .DATA_W(WORD_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_load   (len_load),
        .len_in     (len_val),
        .last_in    (last_val),
        .word_load  (word_load),
        .word_in    (mem_rdata),
        .flush      (flush),
        .need_word  (need_word),
        .buf_empty  (buf_empty),
        .byte_valid (out_valid),
        .byte_data  (out_data),
        .byte_last  (out_last)
    );

    txd_status_reg #(.W(ST_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .set_sent (set_sent),
        .set_exh  (set_exh),
        .set_und  (set_und),
        .clr_we   (stat_clr_we),
        .clr_data (stat_clr_data),
        .status   (tx_status)
    );
endmodule

// File: rtl/txd_chain_reader_chk.sv
// Protocol and timing properties of the chain reader, bound to its ports.
module txd_chain_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  tx_status,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_wdata,
    input logic        out_valid,
    input logic        out_last,
    input logic        out_abort
);
    // Every write-back hands the descriptor over (R5).
    assert_wb_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[31]);

    // The frame end marker only accompanies a byte (R3).
    assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // No fetch while a held word still has bytes to give (R2).
    assert_no_fetch_while_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    // Bytes flow only while the busy bit shows (R12).
    assert_emit_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tx_status[0]);

    // An idle engine leaves memory alone (R12).
    assert_idle_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_status[0] |-> !mem_req);

    // Frame-sent rises only right after a write-back acknowledge (R9).
    assert_sent_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_status[5]) |-> $past(mem_req && mem_we && mem_ack));

    // The abort pulse never overlaps a byte (R7).
    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> !out_valid);
endmodule

bind txd_chain_reader txd_chain_reader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_status (tx_status),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_wdata (mem_wdata),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_abort (out_abort)
);

// File: tb/tb_txd_chain_reader.sv
`timescale 1ns/1ps
module tb_txd_chain_reader;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        qbase_we = 1'b0;
    logic [15:0] qbase_wdata = '0;
    logic        stat_clr_we = 1'b0;
    logic [7:0]  stat_clr_data = '0;
    logic [7:0]  tx_status;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_last, out_abort;
    logic [7:0]  out_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    txd_chain_reader #(.AW(AW), .STALL_LIMIT(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .qbase_we(qbase_we), .qbase_wdata(qbase_wdata),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .tx_status(tx_status),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_abort(out_abort)
    );

    // Word memory with adjustable latency and one stallable address.
    logic [31:0] mem [0:255];
    int          mem_lat = 0;
    int          wcnt = 0;
    logic        stall_en = 1'b0;
    logic [15:0] stall_addr = '0;

    function automatic logic [7:0] exp_byte(input int a);
        return 8'(a * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && !mem_ack && !(stall_en && mem_addr == stall_addr)) begin
            if (wcnt >= mem_lat) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            if (!mem_req) wcnt <= 0;
        end
    end

    // Stream and write monitor, sampled on falling edges.
    logic [7:0] cap [0:1023];
    int cap_n = 0;
    int last_pos [0:63];
    int last_n = 0;
    int abort_n = 0;
    int wr_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                cap[cap_n] <= out_data;
                cap_n      <= cap_n + 1;
                if (out_last) begin
                    last_pos[last_n] <= cap_n;
                    last_n           <= last_n + 1;
                end
            end
            if (out_abort) abort_n <= abort_n + 1;
            if (mem_req && mem_we && mem_ack) wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] bufa, input logic [31:0] ctrl);
        mem[a >> 2]       <= bufa;
        mem[(a >> 2) + 1] <= ctrl;
    endtask

    task automatic set_base(input logic [15:0] b);
        @(negedge clk);
        qbase_we = 1'b1; qbase_wdata = b;
        @(negedge clk);
        qbase_we = 1'b0;
    endtask

    task automatic clr_status(input logic [7:0] m);
        @(negedge clk);
        stat_clr_we = 1'b1; stat_clr_data = m;
        @(negedge clk);
        stat_clr_we = 1'b0; stat_clr_data = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (tx_status[0] && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 3000, "idle timeout", 32'(guard), 32'd0);
        @(negedge clk);
    endtask

    task automatic cmp_bytes(input int from, input int bufa, input int len, input string tag);
        for (int k = 0; k < len; k++)
            chk(cap[from + k] == exp_byte(bufa + k), tag, 32'(cap[from + k]), 32'(exp_byte(bufa + k)));
    endtask

    task automatic t_reset();
        chk(tx_status == 8'h00, "R12 reset status", 32'(tx_status), 32'h0);
        chk(!mem_req, "R12 reset no request", 32'(mem_req), 32'h0);
        chk(!out_valid, "R12 reset no output", 32'(out_valid), 32'h0);
    endtask

    task automatic t_single();
        int s, l, w, guard;
        mem_lat = 0;
        put_desc(32'h100, 32'h200, 32'h0000_8006);
        put_desc(32'h108, 32'h0,   32'hC000_8000);
        set_base(16'h100);
        clr_status(8'hFF);
        s = cap_n; l = last_n; w = wr_n;
        pulse_start();
        chk(mem_req && !mem_we && mem_addr == 16'h100, "R12 first fetch", 32'(mem_addr), 32'h100);
        chk(tx_status[0], "R12 busy", 32'(tx_status), 32'h1);
        guard = 0;
        while (!(mem_req && mem_we && mem_ack) && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        chk(mem_addr == 16'h104, "R1 write-back address", 32'(mem_addr), 32'h104);
        chk(!tx_status[5], "R9 sent before ack", 32'(tx_status), 32'h1);
        @(negedge clk);
        chk(tx_status[5], "R9 sent after ack", 32'(tx_status), 32'h21);
        wait_idle();
        chk(cap_n - s == 6, "R2 byte count", 32'(cap_n - s), 32'd6);
        cmp_bytes(s, 32'h200, 6, "R1 R2 bytes");
        chk(last_n - l == 1 && last_pos[l] == s + 5, "R3 last position", 32'(last_pos[l] - s), 32'd5);
        chk(mem[32'h104 >> 2] == 32'h8000_8006, "R5 write-back", mem[32'h104 >> 2], 32'h8000_8006);
        chk(wr_n - w == 1, "R5 write count", 32'(wr_n - w), 32'd1);
        chk(tx_status == 8'h20, "R9 final status", 32'(tx_status), 32'h20);
    endtask

    task automatic t_multi();
        int s, l, w;
        mem_lat = 1;
        put_desc(32'h100, 32'h210, 32'h0010_0005);
        put_desc(32'h108, 32'h240, 32'h0000_0000);
        put_desc(32'h110, 32'h260, 32'h0000_8003);
        put_desc(32'h118, 32'h280, 32'h0000_8009);
        put_desc(32'h120, 32'h0,   32'hC000_8000);
        set_base(16'h100);
        clr_status(8'hFF);
        s = cap_n; l = last_n; w = wr_n;
        pulse_start();
        wait_idle();
        chk(cap_n - s == 17, "R2 multi count", 32'(cap_n - s), 32'd17);
        cmp_bytes(s, 32'h210, 5, "R2 buffer A");
        cmp_bytes(s + 5, 32'h260, 3, "R2 buffer C");
        cmp_bytes(s + 8, 32'h280, 9, "R2 buffer D");
        chk(last_n - l == 2, "R3 frame count", 32'(last_n - l), 32'd2);
        chk(last_pos[l] == s + 7, "R3 first frame end", 32'(last_pos[l] - s), 32'd7);
        chk(last_pos[l + 1] == s + 16, "R3 second frame end", 32'(last_pos[l + 1] - s), 32'd16);
        chk(mem[32'h104 >> 2] == 32'h8010_0005, "R5 bits kept", mem[32'h104 >> 2], 32'h8010_0005);
        chk(mem[32'h10C >> 2] == 32'h0, "R5 middle untouched", mem[32'h10C >> 2], 32'h0);
        chk(mem[32'h114 >> 2] == 32'h0000_8003, "R5 last untouched", mem[32'h114 >> 2], 32'h0000_8003);
        chk(mem[32'h11C >> 2] == 32'h8000_8009, "R5 next frame", mem[32'h11C >> 2], 32'h8000_8009);
        chk(wr_n - w == 2, "R5 write count", 32'(wr_n - w), 32'd2);
    endtask

    task automatic t_wrap_busy();
        int s, l;
        mem_lat = 0;
        put_desc(32'h100, 32'h300, 32'h4000_8006);
        put_desc(32'h108, 32'h320, 32'h0000_8004);
        put_desc(32'h110, 32'h0,   32'hC000_8000);
        put_desc(32'h180, 32'h340, 32'h0000_8004);
        put_desc(32'h188, 32'h0,   32'hC000_8000);
        set_base(16'h100);
        clr_status(8'hFF);
        s = cap_n; l = last_n;
        pulse_start();
        @(negedge clk);
        start = 1'b1; qbase_we = 1'b1; qbase_wdata = 16'h180;
        @(negedge clk);
        start = 1'b0; qbase_we = 1'b0;
        wait_idle();
        chk(cap_n - s == 6, "R4 R11 byte count", 32'(cap_n - s), 32'd6);
        cmp_bytes(s, 32'h300, 6, "R4 bytes");
        chk(last_n - l == 1, "R4 one frame", 32'(last_n - l), 32'd1);
        chk(mem[32'h10C >> 2] == 32'h0000_8004, "R4 next skipped", mem[32'h10C >> 2], 32'h0000_8004);
        chk(mem[32'h184 >> 2] == 32'h0000_8004, "R11 base write ignored", mem[32'h184 >> 2], 32'h0000_8004);
        chk(!tx_status[0], "R11 no restart", 32'(tx_status), 32'h20);
    endtask

    task automatic t_used_first();
        int s, w;
        put_desc(32'h100, 32'h200, 32'h8000_8004);
        set_base(16'h100);
        clr_status(8'hFF);
        s = cap_n; w = wr_n;
        pulse_start();
        wait_idle();
        chk(cap_n == s, "R6 no bytes", 32'(cap_n - s), 32'd0);
        chk(wr_n == w, "R6 no write", 32'(wr_n - w), 32'd0);
        chk(tx_status == 8'h00, "R6 status", 32'(tx_status), 32'h0);
    endtask

    task automatic t_exhaust();
        int s, l, a;
        put_desc(32'h100, 32'h200, 32'h0000_0003);
        put_desc(32'h108, 32'h0,   32'h8000_0000);
        set_base(16'h100);
        clr_status(8'hFF);
        s = cap_n; l = last_n; a = abort_n;
        pulse_start();
        wait_idle();
        chk(cap_n - s == 3, "R7 bytes", 32'(cap_n - s), 32'd3);
        chk(last_n == l, "R7 no end marker", 32'(last_n - l), 32'd0);
        chk(abort_n - a == 1, "R7 abort pulse", 32'(abort_n - a), 32'd1);
        chk(mem[32'h104 >> 2] == 32'h8800_0003, "R7 write-back", mem[32'h104 >> 2], 32'h8800_0003);
        chk(tx_status == 8'h08, "R7 status", 32'(tx_status), 32'h08);
        clr_status(8'h20);
        chk(tx_status == 8'h08, "R10 other bit kept", 32'(tx_status), 32'h08);
        clr_status(8'h08);
        chk(tx_status == 8'h00, "R10 cleared", 32'(tx_status), 32'h00);
        mem[32'h104 >> 2] <= 32'h0000_8002;
        s = cap_n;
        pulse_start();
        wait_idle();
        chk(cap_n - s == 2, "R7 pointer at base", 32'(cap_n - s), 32'd2);
        cmp_bytes(s, 32'h200, 2, "R7 restart bytes");
    endtask

    task automatic t_underrun();
        int s, l, a;
        mem_lat = 0;
        put_desc(32'h100, 32'h200, 32'h0000_8008);
        put_desc(32'h108, 32'h0,   32'hC000_8000);
        set_base(16'h100);
        clr_status(8'hFF);
        stall_en = 1'b1; stall_addr = 16'h204;
        s = cap_n; l = last_n; a = abort_n;
        pulse_start();
        wait_idle();
        stall_en = 1'b0;
        chk(cap_n - s == 4, "R8 bytes", 32'(cap_n - s), 32'd4);
        chk(last_n == l, "R8 no end marker", 32'(last_n - l), 32'd0);
        chk(abort_n - a == 1, "R8 abort pulse", 32'(abort_n - a), 32'd1);
        chk(mem[32'h104 >> 2] == 32'h9000_8008, "R8 write-back", mem[32'h104 >> 2], 32'h9000_8008);
        chk(tx_status == 8'h10, "R8 status", 32'(tx_status), 32'h10);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] <= {exp_byte(4*i + 3), exp_byte(4*i + 2), exp_byte(4*i + 1), exp_byte(4*i)};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_wrap_busy();
        t_used_first();
        t_exhaust();
        t_underrun();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule